// File: doc/BRIEF.md
# Zero-Sector Flag Tracker

This block keeps one flag bit for every sector of an emulated disk. The flag says that the most recent data written to that sector was entirely zero. A burst of sector writes, such as a disk format, can fill the disk with zeros faster than the backing store can absorb them. The block lets such sectors be recorded as one bit each instead of being buffered as 512 bytes.

Sector data arrives one byte per accepted beat. The sector index is taken from the first beat. When the last byte is accepted, the block either sets that sector's flag (every byte was zero) or clears it (at least one byte was nonzero). Clearing the flag hands the sector back to the normal buffered path.

A lookup port tells the reader whether a sector must be synthesized as zeros rather than fetched. A flush port always presents the lowest-numbered flagged sector. A matching save-done pulse retires that sector, so flagged sectors can be written back at leisure once the burst is over.

Top module: `zsec_tracker`

## Requirements
- R1: After a synchronous reset, `fl_valid`, `lk_ack`, `lk_zero` and `err` are 0 and every sector's flag reads as clear.
- R2: A sector of `SECT_BYTES` bytes that are all zero, written to an in-range index, sets that sector's flag.
- R3: A sector with any nonzero byte, at any byte position, clears that sector's flag, including a flag that was set before.
- R4: A sector's flag changes only when the last byte of its sector is accepted; a lookup during a partly written sector returns the earlier flag value.
- R5: A lookup request (`lk_valid` high) gives `lk_ack` high on the next cycle, with `lk_zero` equal to the flag of `lk_sect`.
- R6: `fl_valid` is high exactly when at least one flag is set, and `fl_sect` is then the lowest index with a set flag. Both outputs are registered and reflect a flag change one cycle after it happens.
- R7: A `done_valid` pulse clears a flag only when `done_sect` equals the `fl_sect` currently presented with `fl_valid` high; any other save-done pulse changes nothing.
- R8: A write sector whose first-beat index is `NUM_SECT` or above is ignored entirely and gives a one-cycle `err` pulse. A lookup of such an index returns `lk_zero` 0 and gives an `err` pulse.
- R9: A synchronous reset asserted while flags are set clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A write byte is present this cycle |
| wr_data | input | DATA_W | Write byte |
| wr_sect | input | IDX_W | Sector index, sampled on the first byte of a sector |
| lk_valid | input | 1 | Lookup request |
| lk_sect | input | IDX_W | Sector index to look up |
| lk_ack | output | 1 | Lookup answer valid (one cycle after the request) |
| lk_zero | output | 1 | Looked-up sector must be produced as zeros |
| fl_valid | output | 1 | At least one flagged sector awaits saving |
| fl_sect | output | IDX_W | Lowest flagged sector index |
| done_valid | input | 1 | Save-done pulse |
| done_sect | input | IDX_W | Sector index the save-done pulse refers to |
| err | output | 1 | Out-of-range index pulse |

## Verification
The flag store is updated on the same edge that accepts the last byte of a sector. A lookup presented at any later edge is therefore answered on the following edge. The flush outputs lag the store by one edge, so the bench waits two cycles after a final byte or a save-done pulse before reading `fl_sect`. An `err` pulse appears on the edge after the offending first byte or lookup, and the bench counts it one cycle later than that. All stimulus is applied on falling edges and every output is sampled on a falling edge, at least one rising edge after its due cycle.

// File: rtl/zsec_pkg.sv
package zsec_pkg;
  localparam int DEF_NUM_SECT   = 1600;
  localparam int DEF_SECT_BYTES = 512;
  localparam int DEF_DATA_W     = 8;
  localparam int DEF_WORD_W     = 16;
endpackage

// File: rtl/zsec_collect.sv
module zsec_collect #(
  parameter int NUM_SECT   = 1600,
  parameter int SECT_BYTES = 512,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = $clog2(NUM_SECT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0] wr_sect,
  output logic             commit_en,
  output logic [IDX_W-1:0] commit_idx,
  output logic             commit_zero,
  output logic             start_bad
);
  localparam int CNT_W = (SECT_BYTES > 1) ? $clog2(SECT_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SECT_BYTES - 1);
  localparam logic [IDX_W:0]   LIMIT    = (IDX_W+1)'(NUM_SECT);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             bad_q;
  logic             acc_q;
  logic             first, last, cur_bad, cur_or;

  always_comb begin
    first       = (cnt_q == '0);
    last        = (cnt_q == LAST_CNT);
    commit_idx  = first ? wr_sect : idx_q;
    cur_bad     = first ? ({1'b0, wr_sect} >= LIMIT) : bad_q;
    cur_or      = (first ? 1'b0 : acc_q) | (|wr_data);
    commit_en   = wr_valid && last && !cur_bad;
    commit_zero = !cur_or;
    start_bad   = wr_valid && first && cur_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      idx_q <= '0;
      bad_q <= 1'b0;
      acc_q <= 1'b0;
    end else if (wr_valid) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      idx_q <= commit_idx;
      bad_q <= cur_bad;
      acc_q <= cur_or;
    end
  end

  p_cnt_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && last) |=> (cnt_q == '0));
  p_commit_range_r8: assert property (@(posedge clk) disable iff (rst)
    commit_en |-> ({1'b0, commit_idx} < LIMIT));
endmodule

// File: rtl/zsec_bitmap.sv
module zsec_bitmap #(
  parameter int NUM_SECT = 1600,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = $clog2(NUM_SECT),
  parameter int WORDS    = (NUM_SECT + WORD_W - 1) / WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit_en,
  input  logic [IDX_W-1:0]        commit_idx,
  input  logic                    commit_zero,
  input  logic                    clr_en,
  input  logic [IDX_W-1:0]        clr_idx,
  input  logic                    lk_valid,
  input  logic [IDX_W-1:0]        lk_sect,
  output logic                    lk_ack,
  output logic                    lk_zero,
  output logic [WORDS*WORD_W-1:0] flags
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SECT);

  logic lk_in_range;
  logic [IDX_W-1:0] lk_safe;

  always_comb begin
    lk_in_range = ({1'b0, lk_sect} < LIMIT);
    lk_safe     = lk_in_range ? lk_sect : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      lk_ack  <= 1'b0;
      lk_zero <= 1'b0;
    end else begin
      if (clr_en)
        flags[clr_idx] <= 1'b0;
      if (commit_en)
        flags[commit_idx] <= commit_zero;
      lk_ack  <= lk_valid;
      lk_zero <= lk_valid && lk_in_range && flags[lk_safe];
    end
  end

  p_lk_ack_r5: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_ack);
  p_bad_lookup_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_in_range) |=> !lk_zero);
endmodule

// File: rtl/zsec_scan.sv
module zsec_scan #(
  parameter int NUM_SECT = 1600,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = $clog2(NUM_SECT),
  parameter int WORDS    = (NUM_SECT + WORD_W - 1) / WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WORDS*WORD_W-1:0] flags,
  output logic                    fl_valid,
  output logic [IDX_W-1:0]        fl_sect
);
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BSEL_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SECT);

  logic [WORDS-1:0]  nonempty;
  logic [WSEL_W-1:0] wsel;
  logic [BSEL_W-1:0] bsel;
  logic [WORD_W-1:0] wsel_bits;
  logic              hit;
  logic [IDX_W-1:0]  sect_c;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign nonempty[w] = |flags[w*WORD_W +: WORD_W];
  end

  always_comb begin
    hit  = 1'b0;
    wsel = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (nonempty[w]) begin
        hit  = 1'b1;
        wsel = WSEL_W'(w);
      end
    end
    wsel_bits = flags[wsel*WORD_W +: WORD_W];
    bsel = '0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (wsel_bits[b])
        bsel = BSEL_W'(b);
    end
    sect_c = IDX_W'(wsel) * IDX_W'(WORD_W) + IDX_W'(bsel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_valid <= 1'b0;
      fl_sect  <= '0;
    end else begin
      fl_valid <= hit;
      fl_sect  <= hit ? sect_c : '0;
    end
  end

  p_sect_range_r6: assert property (@(posedge clk) disable iff (rst)
    fl_valid |-> ({1'b0, fl_sect} < LIMIT));
endmodule

// File: rtl/zsec_tracker.sv
module zsec_tracker
  import zsec_pkg::*;
#(
  parameter int NUM_SECT   = DEF_NUM_SECT,
  parameter int SECT_BYTES = DEF_SECT_BYTES,
  parameter int DATA_W     = DEF_DATA_W,
  parameter int WORD_W     = DEF_WORD_W,
  parameter int IDX_W      = $clog2(NUM_SECT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  wr_sect,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_sect,
  output logic              lk_ack,
  output logic              lk_zero,
  output logic              fl_valid,
  output logic [IDX_W-1:0]  fl_sect,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_sect,
  output logic              err
);
  localparam int WORDS = (NUM_SECT + WORD_W - 1) / WORD_W;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SECT);

  logic                    commit_en, commit_zero, start_bad, clr_en, lk_bad;
  logic [IDX_W-1:0]        commit_idx;
  logic [WORDS*WORD_W-1:0] flags;

  zsec_collect #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES),
                 .DATA_W(DATA_W), .IDX_W(IDX_W)) collect_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sect(wr_sect), .commit_en(commit_en), .commit_idx(commit_idx),
    .commit_zero(commit_zero), .start_bad(start_bad));

  assign clr_en = done_valid && fl_valid && (done_sect == fl_sect);
  assign lk_bad = lk_valid && ({1'b0, lk_sect} >= LIMIT);

  zsec_bitmap #(.NUM_SECT(NUM_SECT), .WORD_W(WORD_W), .IDX_W(IDX_W),
                .WORDS(WORDS)) bitmap_i (
    .clk(clk), .rst(rst), .commit_en(commit_en), .commit_idx(commit_idx),
    .commit_zero(commit_zero), .clr_en(clr_en), .clr_idx(fl_sect),
    .lk_valid(lk_valid), .lk_sect(lk_sect), .lk_ack(lk_ack),
    .lk_zero(lk_zero), .flags(flags));

  zsec_scan #(.NUM_SECT(NUM_SECT), .WORD_W(WORD_W), .IDX_W(IDX_W),
              .WORDS(WORDS)) scan_i (
    .clk(clk), .rst(rst), .flags(flags), .fl_valid(fl_valid),
    .fl_sect(fl_sect));

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= start_bad | lk_bad;
  end

  p_err_lookup_r8: assert property (@(posedge clk) disable iff (rst)
    lk_bad |=> err);
  p_err_write_r8: assert property (@(posedge clk) disable iff (rst)
    start_bad |=> err);
  p_mismatch_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (done_valid && fl_valid && done_sect != fl_sect && !commit_en) |=> $stable(flags));
endmodule

// File: tb/zsec_tracker_tb.sv
`timescale 1ns/1ps
module zsec_tracker_tb_top;
  localparam int NS = 40;
  localparam int SB = 4;
  localparam int IW = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [IW-1:0] wr_sect = '0;
  logic lk_valid = 1'b0;
  logic [IW-1:0] lk_sect = '0;
  logic lk_ack, lk_zero, fl_valid, err;
  logic [IW-1:0] fl_sect;
  logic done_valid = 1'b0;
  logic [IW-1:0] done_sect = '0;

  int tests = 0, fails = 0, err_cnt = 0;
  bit model [NS];
  bit finished = 0;

  always #2.5 clk = ~clk;

  zsec_tracker #(.NUM_SECT(NS), .SECT_BYTES(SB), .DATA_W(8), .WORD_W(8)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sect(wr_sect), .lk_valid(lk_valid), .lk_sect(lk_sect),
    .lk_ack(lk_ack), .lk_zero(lk_zero), .fl_valid(fl_valid),
    .fl_sect(fl_sect), .done_valid(done_valid), .done_sect(done_sect),
    .err(err));

  always @(posedge clk) if (!rst && err) err_cnt++;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // nzpos < 0 : all-zero sector; otherwise byte nzpos is nonzero
  task automatic wr_sector(int s, int nzpos);
    for (int b = 0; b < SB; b++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_sect  = IW'(s);
      wr_data  = (b == nzpos) ? 8'(8'h11 + s) : 8'h00;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    if (s < NS) model[s] = (nzpos < 0);
  endtask

  task automatic lookup(string req, int s, int exp);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_sect  = IW'(s);
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " lk_ack"}, int'(lk_ack), 1);
    check({req, " lk_zero"}, int'(lk_zero), exp);
  endtask

  task automatic done_pulse(int s);
    @(negedge clk);
    done_valid = 1'b1;
    done_sect  = IW'(s);
    @(negedge clk);
    done_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic int lowest();
    for (int s = 0; s < NS; s++) if (model[s]) return s;
    return -1;
  endfunction

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e0, drained;
    for (int s = 0; s < NS; s++) model[s] = 0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 fl_valid", int'(fl_valid), 0);
    check("R1 err", int'(err), 0);
    check("R1 lk_ack idle", int'(lk_ack), 0);
    for (int s = 0; s < NS; s += 13) lookup("R1", s, 0);

    // R2 / R3 sweep over every sector
    for (int s = 0; s < NS; s++)
      wr_sector(s, (s % 3 == 1) ? (s % SB) : -1);
    for (int s = 0; s < NS; s++)
      lookup((s % 3 == 1) ? "R3" : "R2", s, (s % 3 == 1) ? 0 : 1);

    // R6 lowest pending
    idle(2);
    check("R6 fl_valid", int'(fl_valid), 1);
    check("R6 fl_sect", int'(fl_sect), lowest());

    // R7 mismatching save-done is ignored
    done_pulse(2);
    lookup("R7 mismatch keeps flag", 2, 1);
    check("R7 fl_sect unchanged", int'(fl_sect), 0);

    // R3 overwrite a flagged sector with data; R6 next lowest
    wr_sector(0, SB - 1);
    lookup("R3 overwrite", 0, 0);
    idle(1);
    check("R6 next lowest", int'(fl_sect), lowest());

    // R4 flag changes only at the last byte
    for (int b = 0; b < SB - 1; b++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_sect = IW'(1); wr_data = 8'h00;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    lookup("R4 mid-sector", 1, 0);
    @(negedge clk);
    wr_valid = 1'b1; wr_sect = IW'(1); wr_data = 8'h00;
    @(negedge clk);
    wr_valid = 1'b0;
    model[1] = 1;
    lookup("R4 after last byte", 1, 1);
    idle(1);
    check("R4 fl_sect", int'(fl_sect), 1);

    // R8 out-of-range write and lookup
    e0 = err_cnt;
    wr_sector(45, -1);
    idle(2);
    check("R8 write err pulse", err_cnt - e0, 1);
    check("R8 write ignored", int'(fl_sect), lowest());
    e0 = err_cnt;
    lookup("R8 bad lookup", 50, 0);
    idle(1);
    check("R8 lookup err pulse", err_cnt - e0, 1);

    // R6 / R7 drain in ascending order
    drained = 0;
    while (lowest() >= 0) begin
      int s;
      s = lowest();
      check("R6 drain valid", int'(fl_valid), 1);
      check("R6 drain order", int'(fl_sect), s);
      done_pulse(s);
      model[s] = 0;
      drained++;
    end
    idle(1);
    check("R7 drained all", int'(fl_valid), 0);
    for (int s = 0; s < NS; s += 7) lookup("R7 cleared", s, 0);

    // R9 reset clears set flags
    wr_sector(5, -1);
    wr_sector(33, -1);
    idle(2);
    check("R9 pre-reset pending", int'(fl_valid), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model[5] = 0; model[33] = 0;
    check("R9 fl_valid", int'(fl_valid), 0);
    lookup("R9", 5, 0);
    lookup("R9", 33, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule